// File: doc/BRIEF.md
# Indirect Local-Bus Access Bridge

This block gives a host a window of four 64-bit register slots. Through them the host can run single read and write transactions on a 32-bit internal local bus. The host stores write data in a data slot. A single write to the control slot then supplies the direction, the byte count and the bus address, and that same write launches the transaction.

The block acts as a request/acknowledge master on the local bus, and the target may also answer with an error. When the bus acknowledges, the block posts a completion word into a status slot. That word carries a done flag and, for reads, the returned bytes packed most-significant-first at an odd bit offset. Reading the status slot returns its value and clears it.

Control words are numbered from the most significant bit (bit 0 is the MSB of the 64-bit word). Every position below is also given LSB-numbered, which is how the RTL and the ports use it.

Top module: `ibridge_top`

## Requirements
- R1: A host access takes effect only when `hostBytes` is 8 and `hostAddr[2:0]` is 0. Bits `hostAddr[4:3]` then select the slot: 0 control, 1 reset, 2 status, 3 data. Any other access changes no state and reads as zero.
- R2: A control write while idle raises `busReq` on the next cycle. It presents `busWrite` as the inverse of control bit 48 (set means read), `busSize` from bits 59:56 and `busAddr` from bits 31:0.
- R3: A data-slot write stores `hostWdata[63:32]`. A data-slot read returns the stored word in bits 63:32 and zero in bits 31:0.
- R4: Write data is laid onto bus lanes, with lane k being `busWdata[8k+7:8k]`. Lane 0 receives the most significant stored byte, lane 1 the next, and so on. Lanes whose index is not below `busSize` are driven zero.
- R5: A read completion without error sets status to the done flag (bit 11) OR'ed with the read word shifted left by 26. The read word takes lane 0 as its most significant byte, and lanes not below the size read as zero.
- R6: A read completion with `busErr` set still sets done, and its data field, bits 57:26, is all ones.
- R7: A write completion sets status to exactly the done flag (value 0x800), whether or not `busErr` is set.
- R8: A status-slot read returns the status word and clears it on the same clock edge. Reads of the control and reset slots return zero. Writes to the reset and status slots have no effect.
- R9: From launch until the acknowledge, status holds zero and `busReq` stays high with the bus command stable. Control writes in that time are ignored.
- R10: When a status read falls in the acknowledge cycle, the read returns zero and the completion word is kept. When a control write falls in that cycle, it launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | 1 write, 0 read |
| hostAddr | input | HOST_AW | Host byte address |
| hostBytes | input | 4 | Access width in bytes |
| hostWdata | input | 64 | Host write data |
| hostRdata | output | 64 | Host read data, valid in the access cycle |
| busReq | output | 1 | Local-bus request, held until acknowledge |
| busWrite | output | 1 | Bus direction, 1 write |
| busAddr | output | 32 | Bus address |
| busSize | output | 4 | Bus byte count |
| busWdata | output | 32 | Bus write lanes |
| busAck | input | 1 | Target acknowledge, one cycle |
| busErr | input | 1 | Target error, qualified by busAck |
| busRdata | input | 32 | Target read lanes, qualified by busAck |

## Verification
Two pairs of events can land on one clock edge. The first pair is the clear from a host status read and the loading of a completion word. The second is a control write and the acknowledge that ends the current transaction. The bench watches for the cycle in which the target model holds `busAck` high and fires the host access in exactly that cycle. It then judges the result by reading status again on the following access and by checking that `busReq` stays low and that the scoreboard sees no extra bus transaction.

// File: rtl/ibridge_pkg.sv
package ibridge_pkg;
  localparam int HOST_W     = 64;
  localparam int BUS_AW     = 32;
  localparam int BUS_DW     = 32;
  localparam int SIZE_W     = 4;
  localparam int LANES      = BUS_DW / 8;
  localparam int CMD_RD_BIT = 48;
  localparam int SIZE_LSB   = 56;
  localparam int DONE_BIT   = 11;
  localparam int RD_LSB     = 26;
  localparam int FULL_BYTES = HOST_W / 8;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_RST  = 2'd1,
    SLOT_STAT = 2'd2,
    SLOT_DATA = 2'd3
  } slot_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_e;

  typedef struct packed {
    logic launch;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/ibridge_ctrl.sv
module ibridge_ctrl
  import ibridge_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctrlWrEn,
  input  logic    busAck,
  output strobe_t stb,
  output logic    busy
);
  seq_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
    end else begin
      case (state)
        SEQ_IDLE: if (ctrlWrEn) state <= SEQ_BUSY;
        SEQ_BUSY: if (busAck)   state <= SEQ_IDLE;
        default:                state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.launch = (state == SEQ_IDLE) && ctrlWrEn;
    stb.finish = (state == SEQ_BUSY) && busAck;
    busy       = (state == SEQ_BUSY);
  end

  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> busy);

  // R9
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !busAck |=> busy);

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && busAck |=> !busy);
endmodule

// File: rtl/ibridge_dp.sv
module ibridge_dp
  import ibridge_pkg::*;
#(
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [3:0]         hostBytes,
  input  logic [HOST_W-1:0]  hostWdata,
  output logic [HOST_W-1:0]  hostRdata,
  output logic               ctrlWrEn,
  input  strobe_t            stb,
  input  logic               busy,
  input  logic               busAck,
  input  logic               busErr,
  input  logic [BUS_DW-1:0]  busRdata,
  output logic               busWrite,
  output logic [BUS_AW-1:0]  busAddr,
  output logic [SIZE_W-1:0]  busSize,
  output logic [BUS_DW-1:0]  busWdata
);
  localparam logic [HOST_W-1:0] DONE_WORD = HOST_W'(1) << DONE_BIT;

  logic              accOk;
  slot_e             slot;
  logic              statRead;
  logic              dataWrEn;
  logic [BUS_DW-1:0] dataReg;
  logic [HOST_W-1:0] statusReg;
  logic [SIZE_W-1:0] newSize;
  logic [BUS_DW-1:0] wrLanes;
  logic [BUS_DW-1:0] rdWord;
  logic [BUS_DW-1:0] rdField;

  // address decode
  always_comb begin
    accOk    = hostValid && (hostBytes == 4'(FULL_BYTES)) && (hostAddr[2:0] == 3'd0);
    slot     = slot_e'(hostAddr[4:3]);
    ctrlWrEn = accOk && hostWrite && (slot == SLOT_CTRL);
    dataWrEn = accOk && hostWrite && (slot == SLOT_DATA);
    statRead = accOk && !hostWrite && (slot == SLOT_STAT);
    newSize  = hostWdata[SIZE_LSB +: SIZE_W];
  end

  // byte ordering between register words and bus lanes
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrLanes[8*g +: 8] = (SIZE_W'(g) < newSize) ?
                               dataReg[BUS_DW-1-8*g -: 8] : 8'h00;
    assign rdWord[BUS_DW-1-8*g -: 8] = (SIZE_W'(g) < busSize) ?
                                       busRdata[8*g +: 8] : 8'h00;
  end

  assign rdField = busErr ? '1 : rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (dataWrEn) begin
      dataReg <= hostWdata[HOST_W-1 -: BUS_DW];
    end
  end

  // command capture at launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWrite <= 1'b0;
      busAddr  <= '0;
      busSize  <= '0;
      busWdata <= '0;
    end else if (stb.launch) begin
      busWrite <= !hostWdata[CMD_RD_BIT];
      busAddr  <= hostWdata[BUS_AW-1:0];
      busSize  <= newSize;
      busWdata <= wrLanes;
    end
  end

  // completion word; a completion takes priority over a clearing read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
    end else if (stb.launch) begin
      statusReg <= '0;
    end else if (stb.finish) begin
      if (busWrite) statusReg <= DONE_WORD;
      else          statusReg <= DONE_WORD | (HOST_W'(rdField) << RD_LSB);
    end else if (statRead) begin
      statusReg <= '0;
    end
  end

  always_comb begin
    hostRdata = '0;
    if (accOk && !hostWrite) begin
      case (slot)
        SLOT_STAT: hostRdata = statusReg;
        SLOT_DATA: hostRdata = {dataReg, {(HOST_W-BUS_DW){1'b0}}};
        default:   hostRdata = '0;
      endcase
    end
  end

  // R9
  stat_busy_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusReg == '0);

  // R9
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !busAck |=> $stable(busAddr) && $stable(busWdata) &&
                        $stable(busSize) && $stable(busWrite));

  // R7
  wr_done_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish && busWrite |=> statusReg == DONE_WORD);

  // R5
  rd_done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish && !busWrite |=> statusReg[DONE_BIT]);

  // R6
  rd_err_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish && !busWrite && busErr |=> statusReg[RD_LSB +: BUS_DW] == '1);

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRead && !stb.finish && !stb.launch |=> statusReg == '0);

  // R4
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && busWrite && busSize == SIZE_W'(1) |-> busWdata[BUS_DW-1:8] == '0);
endmodule

// File: rtl/ibridge_top.sv
module ibridge_top
  import ibridge_pkg::*;
#(
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [3:0]         hostBytes,
  input  logic [63:0]        hostWdata,
  output logic [63:0]        hostRdata,
  output logic               busReq,
  output logic               busWrite,
  output logic [31:0]        busAddr,
  output logic [3:0]         busSize,
  output logic [31:0]        busWdata,
  input  logic               busAck,
  input  logic               busErr,
  input  logic [31:0]        busRdata
);
  strobe_t stb;
  logic    ctrlWrEn;
  logic    busy;

  ibridge_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWrEn (ctrlWrEn),
    .busAck   (busAck),
    .stb      (stb),
    .busy     (busy)
  );

  ibridge_dp #(.HOST_AW(HOST_AW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostValid (hostValid),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .hostBytes (hostBytes),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .ctrlWrEn  (ctrlWrEn),
    .stb       (stb),
    .busy      (busy),
    .busAck    (busAck),
    .busErr    (busErr),
    .busRdata  (busRdata),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWdata  (busWdata)
  );

  assign busReq = busy;
endmodule

// File: tb/ibridge_top_tb_top.sv
`timescale 1ns/1ps
module ibridge_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [3:0]  hostBytes = 4'd8;
  logic [63:0] hostWdata = '0;
  logic [63:0] hostRdata;
  logic        busReq, busWrite;
  logic [31:0] busAddr, busWdata;
  logic [3:0]  busSize;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;
  logic [31:0] busRdata = '0;

  int checks = 0;
  int errors = 0;

  int          tgtLat = 0;
  logic        tgtErr = 1'b0;
  logic [31:0] tgtData = '0;
  int          tgtCnt = 0;

  typedef struct {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  size;
    logic [31:0] wdata;
  } busItem_t;
  busItem_t expQ[$];

  localparam logic [4:0] A_CTRL = 5'h00, A_RST = 5'h08, A_STAT = 5'h10, A_DATA = 5'h18;
  localparam logic [63:0] DONE = 64'h800;

  always #5 clk = ~clk;

  ibridge_top dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostBytes(hostBytes), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busAck(busAck), .busErr(busErr), .busRdata(busRdata)
  );

  // target model with programmable latency and error injection
  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0;
      tgtCnt <= 0;
    end else if (busAck) begin
      busAck <= 1'b0;
      tgtCnt <= 0;
    end else if (busReq) begin
      if (tgtCnt >= tgtLat) begin
        busAck   <= 1'b1;
        busErr   <= tgtErr;
        busRdata <= tgtData;
      end else begin
        tgtCnt <= tgtCnt + 1;
      end
    end
  end

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares each handshake against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && busReq && busAck) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R9 actual=unexpected bus transaction addr %h expected=none", busAddr);
      end else begin
        busItem_t e;
        e = expQ.pop_front();
        if (busWrite !== e.wr || busAddr !== e.addr || busSize !== e.size ||
            (e.wr && busWdata !== e.wdata)) begin
          errors++;
          $display("FAIL R2/R4 actual=%b %h %h %h expected=%b %h %h %h",
                   busWrite, busAddr, busSize, busWdata, e.wr, e.addr, e.size, e.wdata);
        end
      end
    end
  end

  task automatic hostAcc(input bit sync, input logic wr, input logic [4:0] a,
                         input logic [3:0] nb, input logic [63:0] wd,
                         output logic [63:0] rd);
    if (sync) @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostBytes = nb; hostWdata = wd;
    #1 rd = hostRdata;
    @(posedge clk);
    #1 hostValid = 1'b0; hostWrite = 1'b0; hostBytes = 4'd8;
  endtask

  task automatic hostWr(input logic [4:0] a, input logic [63:0] wd);
    logic [63:0] d;
    hostAcc(1'b1, 1'b1, a, 4'd8, wd, d);
  endtask

  task automatic hostRd(input logic [4:0] a, output logic [63:0] rd);
    hostAcc(1'b1, 1'b0, a, 4'd8, 64'd0, rd);
  endtask

  function automatic logic [63:0] ctrlWord(input logic rd, input logic [3:0] sz, input logic [31:0] ad);
    return (64'(rd) << 48) | (64'(sz) << 56) | 64'(ad);
  endfunction

  function automatic logic [31:0] sizeMask(input logic [3:0] sz);
    return (sz == 4'd1) ? 32'hFF00_0000 : (sz == 4'd2) ? 32'hFFFF_0000 : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] laneWr(input logic [31:0] d, input logic [3:0] sz);
    logic [31:0] m;
    m = sizeMask(sz) & d;
    return {m[7:0], m[15:8], m[23:16], m[31:24]};
  endfunction

  function automatic logic [63:0] rdStatus(input logic [31:0] lanes, input logic [3:0] sz, input logic err);
    logic [31:0] w;
    w = {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]} & sizeMask(sz);
    if (err) w = 32'hFFFF_FFFF;
    return DONE | (64'(w) << 26);
  endfunction

  task automatic waitIdle();
    while (busReq) @(negedge clk);
  endtask

  task automatic runWrite(input logic [31:0] d, input logic [3:0] sz, input logic [31:0] ad,
                          input int lat, input logic err);
    logic [63:0] r;
    busItem_t e;
    tgtLat = lat; tgtErr = err;
    hostWr(A_DATA, {d, 32'h5A5A_5A5A});
    e.wr = 1'b1; e.addr = ad; e.size = sz; e.wdata = laneWr(d, sz);
    expQ.push_back(e);
    hostWr(A_CTRL, ctrlWord(1'b0, sz, ad));
    waitIdle();
    hostRd(A_STAT, r);
    check64("R7 write status", r, DONE);
    hostRd(A_STAT, r);
    check64("R8 cleared after read", r, 64'd0);
  endtask

  task automatic runRead(input logic [31:0] lanes, input logic [3:0] sz, input logic [31:0] ad,
                         input int lat, input logic err, input string req);
    logic [63:0] r;
    busItem_t e;
    tgtLat = lat; tgtErr = err; tgtData = lanes;
    e.wr = 1'b0; e.addr = ad; e.size = sz; e.wdata = '0;
    expQ.push_back(e);
    hostWr(A_CTRL, ctrlWord(1'b1, sz, ad));
    waitIdle();
    hostRd(A_STAT, r);
    check64(req, r, rdStatus(lanes, sz, err));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [63:0] r;
    busItem_t e;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state
    hostRd(A_STAT, r);
    check64("R8 reset status", r, 64'd0);
    check64("R9 reset busReq", {63'd0, busReq}, 64'd0);

    // R3 data slot
    hostWr(A_DATA, 64'hA1B2_C3D4_1111_2222);
    hostRd(A_DATA, r);
    check64("R3 data readback", r, 64'hA1B2_C3D4_0000_0000);

    // R1 partial-width and misaligned accesses ignored
    hostAcc(1'b1, 1'b1, A_DATA, 4'd4, 64'hDEAD_BEEF_0000_0000, r);
    hostAcc(1'b1, 1'b1, 5'h1C, 4'd8, 64'hDEAD_BEEF_0000_0000, r);
    hostRd(A_DATA, r);
    check64("R1 narrow write ignored", r, 64'hA1B2_C3D4_0000_0000);
    hostAcc(1'b1, 1'b0, A_DATA, 4'd4, 64'd0, r);
    check64("R1 narrow read zero", r, 64'd0);

    // R8 control and reset slots read zero
    hostRd(A_CTRL, r);
    check64("R8 control reads zero", r, 64'd0);
    hostRd(A_RST, r);
    check64("R8 reset reads zero", r, 64'd0);

    // R2 R4 R7 writes of 4, 2, 1 bytes, one with error
    runWrite(32'hA1B2_C3D4, 4'd4, 32'h1234_5678, 0, 1'b0);
    runWrite(32'h0102_0304, 4'd2, 32'hCAFE_0010, 3, 1'b0);
    runWrite(32'hF0E1_D2C3, 4'd1, 32'h0000_0FFC, 1, 1'b1);

    // R5 reads of 4, 2, 1 bytes; R6 read error
    runRead(32'h4433_2211, 4'd4, 32'h8000_0000, 2, 1'b0, "R5 read 4 bytes");
    runRead(32'h4433_2211, 4'd2, 32'h8000_0004, 0, 1'b0, "R5 read 2 bytes");
    runRead(32'h4433_2211, 4'd1, 32'h8000_0008, 4, 1'b0, "R5 read 1 byte");
    runRead(32'h4433_2211, 4'd4, 32'h8000_000C, 1, 1'b1, "R6 read error ones");

    // R1 narrow status read neither returns nor clears
    runRead(32'h0000_00AB, 4'd1, 32'h10, 0, 1'b0, "R5 read small");
    hostWr(A_CTRL, ctrlWord(1'b1, 4'd1, 32'h14));
    e.wr = 1'b0; e.addr = 32'h14; e.size = 4'd1; e.wdata = '0;
    expQ.push_back(e);
    waitIdle();
    hostAcc(1'b1, 1'b0, A_STAT, 4'd2, 64'd0, r);
    check64("R1 narrow status read zero", r, 64'd0);
    // R8 status and reset writes have no effect
    hostWr(A_STAT, 64'd0);
    hostWr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    hostRd(A_STAT, r);
    check64("R8 status kept after writes", r, rdStatus(32'h0000_00AB, 4'd1, 1'b0));

    // R9 busy window: status zero, control writes ignored
    tgtLat = 8; tgtErr = 1'b0; tgtData = 32'h7766_5544;
    e.wr = 1'b0; e.addr = 32'h200; e.size = 4'd4; e.wdata = '0;
    expQ.push_back(e);
    hostWr(A_CTRL, ctrlWord(1'b1, 4'd4, 32'h200));
    hostRd(A_STAT, r);
    check64("R9 status zero while busy", r, 64'd0);
    hostWr(A_CTRL, ctrlWord(1'b0, 4'd4, 32'h300));
    waitIdle();
    hostRd(A_STAT, r);
    check64("R9 first transaction result", r, rdStatus(32'h7766_5544, 4'd4, 1'b0));
    check64("R9 no second request", {63'd0, busReq}, 64'd0);

    // R10 status read in the acknowledge cycle
    tgtLat = 5; tgtData = 32'h0D0C_0B0A;
    e.wr = 1'b0; e.addr = 32'h400; e.size = 4'd4; e.wdata = '0;
    expQ.push_back(e);
    hostWr(A_CTRL, ctrlWord(1'b1, 4'd4, 32'h400));
    @(negedge clk);
    while (!busAck) @(negedge clk);
    hostAcc(1'b0, 1'b0, A_STAT, 4'd8, 64'd0, r);
    check64("R10 read in ack cycle returns zero", r, 64'd0);
    hostRd(A_STAT, r);
    check64("R10 completion kept", r, rdStatus(32'h0D0C_0B0A, 4'd4, 1'b0));

    // R10 control write in the acknowledge cycle
    tgtLat = 2;
    e.wr = 1'b1; e.addr = 32'h500; e.size = 4'd4; e.wdata = laneWr(32'hA1B2_C3D4, 4'd4);
    expQ.push_back(e);
    hostWr(A_DATA, 64'hA1B2_C3D4_0000_0000);
    hostWr(A_CTRL, ctrlWord(1'b0, 4'd4, 32'h500));
    @(negedge clk);
    while (!busAck) @(negedge clk);
    hostAcc(1'b0, 1'b1, A_CTRL, 4'd8, ctrlWord(1'b1, 4'd4, 32'h600), r);
    @(negedge clk);
    check64("R10 control in ack cycle ignored", {63'd0, busReq}, 64'd0);
    hostRd(A_STAT, r);
    check64("R10 write completion", r, DONE);

    repeat (5) @(negedge clk);
    check64("R9 scoreboard drained", 64'(expQ.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule